// File: doc/BRIEF.md
# Multi-Queue Pair Concentrator

Several filter lanes each produce accepted pairs at their own rate. This block gives every lane a small private FIFO and drains all of them into one output stream that feeds a single downstream pipeline. The output uses a valid/ready handshake. At most one entry leaves per cycle, taken from the queue the arbiter grants.

The arbiter works in two tiers. Queues that are completely full are served before queues that merely hold data. Inside whichever tier is active, the choice rotates: the search starts at the lane after the one last granted. A stall output tells the upstream broadcast to pause while two or more queues are within one entry of full.

Top module: `pair_concentrator`

## Requirements
- R1: After reset every queue is empty, `out_valid_o` is 0, `stall_o` is 0 and the rotation pointer is at lane 0.
- R2: Entries leave each lane's queue in the order they were accepted.
- R3: A push into a lane whose queue holds DEPTH entries at the start of the cycle is dropped, even if the same queue is popped in that cycle. That entry never appears at the output.
- R4: An entry is removed only in a cycle where `out_valid_o` and `out_ready_i` are both 1, and at most one entry is removed per cycle. While `out_ready_i` is 0 and nothing is pushed, the output does not change.
- R5: When at least one queue is full, the granted lane is a full queue.
- R6: Within the active tier (the full queues, or else the non-empty queues), the grant goes to the first eligible lane found by searching upward from the pointer, wrapping after lane N_LANES-1. The pointer starts at lane 0. After each removal it moves to the lane after the one granted.
- R7: `stall_o` is 1 exactly when more than one queue holds at least DEPTH-1 entries.
- R8: `out_valid_o` is 1 exactly when at least one queue is non-empty.
- R9: `out_lane_o` gives the index of the granted lane. `out_data_o` is the oldest entry of that lane. Lane k's input is bits [k*DATA_W +: DATA_W] of `lane_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_valid_i | input | N_LANES | Per-lane push strobe |
| lane_data_i | input | N_LANES*DATA_W | Packed per-lane push data |
| stall_o | output | 1 | Upstream throttle |
| out_valid_o | output | 1 | Output entry available |
| out_data_o | output | DATA_W | Oldest entry of the granted lane |
| out_lane_o | output | $clog2(N_LANES) | Index of the granted lane |
| out_ready_i | input | 1 | Downstream accepts the entry |

## Verification
Two conditions are hard to reach from the ports: a full queue competing with non-empty queues, and a push arriving at a queue that is already full. Both need the producers to outrun the consumer for a long time. The stimulus reaches them with phases in which pushes are dense and `out_ready_i` is mostly low, so several queues fill together and stall appears. These phases alternate with lighter phases that let the rotation pointer move through every lane. Each push carries its lane number and a per-lane sequence number, so any loss, duplication or reordering shows up when the output is compared with the reference model.

// File: rtl/conc_pkg.sv
package conc_pkg;
  function automatic int wrap_idx(input int v, input int n);
    return (v >= n) ? v - n : v;
  endfunction
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              push_ok;

  // full is judged on the start-of-cycle count
  assign push_ok = push_i && (count != CNT_W'(DEPTH));
  assign head_o  = mem[rd_ptr];
  assign count_o = count;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_i)   rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH)); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count != '0); // R4
endmodule

// File: rtl/rr_prio_arbiter.sv
module rr_prio_arbiter #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     full_i,
  input  logic [N-1:0]     nonempty_i,
  input  logic             advance_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  import conc_pkg::*;

  logic [IDX_W-1:0] ptr;
  logic [N-1:0]     req;

  assign req = (|full_i) ? full_i : nonempty_i;

  always_comb begin
    int  j;
    logic found;
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    for (int i = 0; i < N; i++) begin
      j = wrap_idx(int'(ptr) + i, N);
      if (!found && req[j]) begin
        found     = 1'b1;
        gnt_o[j]  = 1'b1;
        gnt_idx_o = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr <= '0;
    else if (advance_i) ptr <= IDX_W'(wrap_idx(int'(gnt_idx_o) + 1, N));
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R4
  AST_FULL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|full_i) |-> (|(gnt_o & full_i))); // R5
  AST_GNT_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (|(gnt_o & nonempty_i))); // R6
endmodule

// File: rtl/pair_concentrator.sv
module pair_concentrator #(
  parameter int N_LANES = 8,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_LANES-1:0]        lane_valid_i,
  input  logic [N_LANES*DATA_W-1:0] lane_data_i,
  output logic                      stall_o,
  output logic                      out_valid_o,
  output logic [DATA_W-1:0]         out_data_o,
  output logic [IDX_W-1:0]          out_lane_o,
  input  logic                      out_ready_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0]  head  [N_LANES];
  logic [CNT_W-1:0]   cnt   [N_LANES];
  logic [N_LANES-1:0] full_v, afull_v, ne_v, gnt, pop_v;
  logic               take;

  assign take  = out_valid_o && out_ready_i;
  assign pop_v = gnt & {N_LANES{take}};

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    lane_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (lane_valid_i[k]),
      .data_i  (lane_data_i[k*DATA_W +: DATA_W]),
      .pop_i   (pop_v[k]),
      .head_o  (head[k]),
      .count_o (cnt[k])
    );
    assign full_v[k]  = cnt[k] == CNT_W'(DEPTH);
    assign afull_v[k] = cnt[k] >= CNT_W'(DEPTH - 1);
    assign ne_v[k]    = cnt[k] != '0;
  end

  rr_prio_arbiter #(.N(N_LANES)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .full_i     (full_v),
    .nonempty_i (ne_v),
    .advance_i  (take),
    .gnt_o      (gnt),
    .gnt_idx_o  (out_lane_o)
  );

  assign out_valid_o = |ne_v;
  assign out_data_o  = head[out_lane_o];
  assign stall_o     = $countones(afull_v) > 1;

  AST_STALL_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> out_valid_o); // R7
  AST_VALID_GRANTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $onehot(gnt)); // R8
endmodule

// File: tb/pair_concentrator_test.sv
module pair_concentrator_test;
  localparam int N  = 8;
  localparam int D  = 8;
  localparam int W  = 32;
  localparam int IW = $clog2(N);

  logic           clk = 0, rst_ni = 0;
  logic [N-1:0]   lane_valid = '0;
  logic [N*W-1:0] lane_data = '0;
  logic           out_ready = 0;
  logic           stall, out_valid;
  logic [W-1:0]   out_data;
  logic [IW-1:0]  out_lane;

  always #5 clk = ~clk;

  pair_concentrator #(.N_LANES(N), .DEPTH(D), .DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .lane_valid_i(lane_valid), .lane_data_i(lane_data),
    .stall_o(stall), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_lane_o(out_lane), .out_ready_i(out_ready));

  int checks = 0, fails = 0, valid_cycles = 0;
  logic [W-1:0] mq [N][$];
  int ptr = 0;
  int seq [N];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pick();
    bit any_full = 0;
    for (int k = 0; k < N; k++) if (mq[k].size() == D) any_full = 1;
    for (int i = 0; i < N; i++) begin
      int j = (ptr + i) % N;
      if (any_full ? (mq[j].size() == D) : (mq[j].size() != 0)) return j;
    end
    return -1;
  endfunction

  task automatic step(input logic [N-1:0] v, input logic rdy);
    int g, naf;
    bit was_full [N];
    @(negedge clk);
    lane_valid = v;
    out_ready  = rdy;
    for (int k = 0; k < N; k++) lane_data[k*W +: W] = {8'(k), 24'(seq[k])};
    #1;
    g = pick();
    naf = 0;
    for (int k = 0; k < N; k++) if (mq[k].size() >= D - 1) naf++;
    chk(out_valid == (g >= 0), "R8 valid", out_valid, g >= 0);
    chk(stall == (naf > 1), "R7 stall", stall, naf > 1);
    if (g >= 0) begin
      valid_cycles++;
      chk(int'(out_lane) == g, "R5 R6 R9 lane", out_lane, g);
      chk(out_data == mq[g][0], "R2 R3 data", out_data, mq[g][0]);
    end
    @(posedge clk);
    for (int k = 0; k < N; k++) was_full[k] = mq[k].size() == D;
    if (g >= 0 && rdy) begin
      void'(mq[g].pop_front());
      ptr = (g + 1) % N;
    end
    for (int k = 0; k < N; k++) if (v[k]) begin
      if (!was_full[k]) mq[k].push_back({8'(k), 24'(seq[k])});
      seq[k]++;
    end
  endtask

  function automatic logic [N-1:0] rand_mask(input int pct);
    logic [N-1:0] m;
    for (int k = 0; k < N; k++) m[k] = ($urandom_range(99) < pct);
    return m;
  endfunction

  initial begin
    #(10 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] hold_d;
    logic [IW-1:0] hold_l;
    for (int k = 0; k < N; k++) seq[k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(stall == 0, "R1 stall", stall, 0);
    @(negedge clk) rst_ni = 1;

    // R6: pointer starts at lane 0; push lanes 3 and 6 then drain
    step(8'b0100_1000, 0);
    step('0, 1);
    step('0, 1);
    step('0, 0);
    // R5 R3: fill lane 5 past full, lanes 1,2 partly
    for (int i = 0; i < D + 2; i++) step(8'b0010_0000 | (i < 3 ? 8'b0000_0110 : 8'b0), 0);
    // R4: nothing moves while not ready
    @(negedge clk); #1; hold_d = out_data; hold_l = out_lane;
    repeat (3) step('0, 0);
    @(negedge clk); #1;
    chk(out_data == hold_d && out_lane == hold_l, "R4 hold", out_data, hold_d);
    // R3: push into full while popping it
    step(8'b0010_0000, 1);
    repeat (20) step('0, 1);
    // light traffic
    repeat (600) step(rand_mask(15), $urandom_range(99) < 80);
    // heavy traffic, slow consumer
    repeat (800) step(rand_mask(70), $urandom_range(99) < 30);
    // mixed
    repeat (800) step(rand_mask(40), $urandom_range(99) < 50);
    // drain
    repeat (N * D + 10) step('0, 1);
    @(negedge clk); #1;
    chk(out_valid == 0, "R2 drained", out_valid, 0);
    $display("valid cycles: %0d", valid_cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule